// File: doc/BRIEF.md
# I/O Translation Unit Register Block

This block holds the software-visible control and status state of an I/O address-translation unit. Software reaches it with single 32-bit word accesses over a simple select/write/address bus. Read data comes back one cycle after the request. Every named register keeps only its own writable bits and ORs in its own constant bits. All other word offsets in the 16 KB window act as plain 32-bit storage.

The block drives three outputs for the translation datapath: the enable bit, the page-table base, and the start address of the translation window. The window start is decoded from a 3-bit size field when the control register is written. The window always ends at the top of the 32-bit space and spans 16 MB shifted left by the field.

The block also owns the fault interrupt. A two-state machine, `IRQ_QUIET` and `IRQ_RAISED`, drives it. The transition `QUIET->RAISED` fires when the translation logic pulses the fault-capture input. That pulse also loads the fault status and fault address in the same cycle. The transition `RAISED->QUIET` fires when software reads or writes either fault register in a cycle without a capture. In every other cycle the state holds. A capture that coincides with a software access wins, both for the register contents and for the interrupt.

Top module: `iommu_csr`

## Requirements
- R1: After reset the block reads as follows: control = VERSION in bits [31:24] and zero below; arbitration-enable (byte offset 0x2000) = 0x00000008; fault status (0x1000) = 0x00800000; arbiter-enable (0x1008) = 0x00000003; mask-ID (0x3018) = 0x23000000; every other word = 0. In the same state, `window_base` = 0 and `irq` = 0.
- R2: A write to control (0x0000) stores only the bits under 0x0000001d. Bits [31:24] always read as VERSION, and bit 0 drives `xlate_en`.
- R3: A control write sets `window_base` to 0xFFFFFFFF shifted left by (24 + bits [4:2] of the written data). This gives 0xff000000 for field 0 and 0x80000000 for field 7. The value changes in the cycle after the write and at no other time.
- R4: Page-table base (0x0004) keeps bits under 0x07fffc00 and drives `table_base`. The TLB-flush word (0x0014) and page-flush word (0x0018) keep all 32 bits.
- R5: Fault status (0x1000) keeps written bits under 0xff0fffff, and bit 23 always reads as 1. Fault address (0x1004) keeps all 32 written bits.
- R6: Arbiter-enable (0x1008) keeps bits under 0x801f000f with bit 0 forced to 1. The four slot-configuration words at 0x1010, 0x1014, 0x1018 and 0x101c keep bits under 0x00010003. Arbitration-enable (0x2000) keeps bits under 0x001f0000 with bit 3 forced to 1.
- R7: A write to mask-ID (0x3018) ORs bits [23:0] of the data into the current value, so no bit ever clears.
- R8: A read or a write of fault status or fault address, in a cycle without a capture, deasserts `irq` in the following cycle.
- R9: A cycle with `flt_load` high has three effects from the next cycle on: fault status = `flt_status` OR 0x00800000, fault address = `flt_addr`, and `irq` = 1. These hold even when software writes or touches a fault register in the same cycle.
- R10: A read request returns the addressed word on `bus_rdata`, with `bus_rvalid` high, in the next cycle. The value returned is the one held before any same-cycle capture.
- R11: Word offsets not named above store all 32 bits. Byte address bits [1:0] are ignored.
- R12: With no capture and no fault-register access, `irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| flt_load | input | 1 | Fault capture pulse from the translation logic |
| flt_status | input | 32 | Fault status to capture |
| flt_addr | input | 32 | Faulting address to capture |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| window_base | output | 32 | Start address of the translation window |
| table_base | output | 32 | Page-table base register value |
| irq | output | 1 | Fault interrupt |

## Verification
The assertions check the interrupt state machine on every cycle: raise on capture, drop on a fault-register touch, hold otherwise. They also check on every cycle that the window start is always a contiguous run of top ones, that mask-ID bits never clear, that fault-status reads carry bit 23, and that reads answer one cycle later. The per-register write masks, the forced bits, the reset values, the exact window value for each size code, and the contents after a capture collides with a software write can only be shown by the bench. It compares read-back data against its own model under random and directed access patterns.

// File: rtl/iommu_csr_pkg.sv
package iommu_csr_pkg;

    localparam int unsigned DW = 32;

    // word indices (byte offset >> 2)
    localparam int unsigned W_CTRL   = 'h000;
    localparam int unsigned W_TBASE  = 'h001;
    localparam int unsigned W_FSTAT  = 'h400;
    localparam int unsigned W_FADDR  = 'h401;
    localparam int unsigned W_ARB    = 'h402;
    localparam int unsigned W_SLOT0  = 'h404;
    localparam int unsigned W_ARBEN  = 'h800;
    localparam int unsigned W_MASKID = 'hC06;

    localparam int unsigned NUM_SLOTS = 4;

    localparam logic [DW-1:0] M_CTRL   = 32'h0000_001d;
    localparam logic [DW-1:0] M_TBASE  = 32'h07ff_fc00;
    localparam logic [DW-1:0] M_FSTAT  = 32'hff0f_ffff;
    localparam logic [DW-1:0] F_FSTAT  = 32'h0080_0000;
    localparam logic [DW-1:0] M_ARB    = 32'h801f_000f;
    localparam logic [DW-1:0] F_ARB    = 32'h0000_0001;
    localparam logic [DW-1:0] M_SLOT   = 32'h0001_0003;
    localparam logic [DW-1:0] M_ARBEN  = 32'h001f_0000;
    localparam logic [DW-1:0] F_ARBEN  = 32'h0000_0008;
    localparam logic [DW-1:0] M_MASKID = 32'h00ff_ffff;

    localparam logic [DW-1:0] R_ARB    = 32'h0000_0003;
    localparam logic [DW-1:0] R_MASKID = 32'h2300_0000;

    typedef enum logic [3:0] {
        SEL_PLAIN,
        SEL_CTRL,
        SEL_TBASE,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_ARB,
        SEL_SLOT,
        SEL_ARBEN,
        SEL_MASKID
    } csr_sel_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/iommu_csr_decode.sv
module iommu_csr_decode
    import iommu_csr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] idx,
    output csr_sel_e         sel
);
    localparam int SLOT_HI_W = IDX_W - 2;

    always_comb begin
        sel = SEL_PLAIN;
        if (idx == IDX_W'(W_CTRL))                               sel = SEL_CTRL;
        else if (idx == IDX_W'(W_TBASE))                         sel = SEL_TBASE;
        else if (idx == IDX_W'(W_FSTAT))                         sel = SEL_FSTAT;
        else if (idx == IDX_W'(W_FADDR))                         sel = SEL_FADDR;
        else if (idx == IDX_W'(W_ARB))                           sel = SEL_ARB;
        else if (idx[IDX_W-1:2] == SLOT_HI_W'(W_SLOT0 >> 2))     sel = SEL_SLOT;
        else if (idx == IDX_W'(W_ARBEN))                         sel = SEL_ARBEN;
        else if (idx == IDX_W'(W_MASKID))                        sel = SEL_MASKID;
    end
endmodule

// File: rtl/iommu_csr_window.sv
module iommu_csr_window #(
    parameter int DW       = 32,
    parameter int FIELD_W  = 3,
    parameter int MIN_LOG2 = 24
) (
    input  logic [FIELD_W-1:0] size_code,
    output logic [DW-1:0]      base
);
    localparam int MAX_CODE = (1 << FIELD_W) - 1;

    logic [DW-1:0] cand [MAX_CODE+1];

    for (genvar k = 0; k <= MAX_CODE; k++) begin : g_code
        assign cand[k] = {DW{1'b1}} << (MIN_LOG2 + k);
    end

    assign base = cand[size_code];
endmodule

// File: rtl/iommu_csr_irq_fsm.sv
module iommu_csr_irq_fsm
    import iommu_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic sw_touch,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (capture)              state_d = IRQ_RAISED;
            IRQ_RAISED: if (sw_touch && !capture) state_d = IRQ_QUIET;
            default:                              state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    a_r9_capture_raises: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> irq);
    a_r8_touch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_touch && !capture) |=> !irq);
    a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_touch && !capture) |=> $stable(irq));
endmodule

// File: rtl/iommu_csr_store.sv
module iommu_csr_store #(
    parameter int DEPTH = 4096,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/iommu_csr.sv
module iommu_csr
    import iommu_csr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41,
    parameter int         ADDR_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              flt_load,
    input  logic [31:0]       flt_status,
    input  logic [31:0]       flt_addr,
    output logic              xlate_en,
    output logic [31:0]       window_base,
    output logic [31:0]       table_base,
    output logic              irq
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [DW-1:0] VER_BITS = {VERSION, 24'h0};

    logic [IDX_W-1:0] idx;
    csr_sel_e         sel;
    logic             wr_en, rd_en, sw_touch;
    logic [DW-1:0]    win_next, plain_rd, rd_val;
    logic             unused_lsb;

    logic [DW-1:0] ctrl_q, tbase_q, fstat_q, faddr_q, arb_q, arben_q, maskid_q, window_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;
    logic [DW-1:0] slot_q [NUM_SLOTS];

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign wr_en      = bus_sel && bus_wr;
    assign rd_en      = bus_sel && !bus_wr;
    assign sw_touch   = bus_sel && ((sel == SEL_FSTAT) || (sel == SEL_FADDR));

    iommu_csr_decode #(.IDX_W(IDX_W)) u_decode (
        .idx (idx),
        .sel (sel)
    );

    iommu_csr_window #(.DW(DW), .FIELD_W(3), .MIN_LOG2(24)) u_window (
        .size_code (bus_wdata[4:2]),
        .base      (win_next)
    );

    iommu_csr_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (flt_load),
        .sw_touch (sw_touch),
        .irq      (irq)
    );

    iommu_csr_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && (sel == SEL_PLAIN)),
        .waddr (idx),
        .wdata (bus_wdata),
        .raddr (idx),
        .rdata (plain_rd)
    );

    // control register and the window start decoded from it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= VER_BITS;
            window_q <= '0;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl_q   <= (bus_wdata & M_CTRL) | VER_BITS;
            window_q <= win_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       tbase_q <= '0;
        else if (wr_en && sel == SEL_TBASE) tbase_q <= bus_wdata & M_TBASE;
    end

    // fault registers: a capture overrides a same-cycle software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstat_q <= F_FSTAT;
            faddr_q <= '0;
        end else if (flt_load) begin
            fstat_q <= flt_status | F_FSTAT;
            faddr_q <= flt_addr;
        end else if (wr_en && sel == SEL_FSTAT) begin
            fstat_q <= (bus_wdata & M_FSTAT) | F_FSTAT;
        end else if (wr_en && sel == SEL_FADDR) begin
            faddr_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       arb_q <= R_ARB;
        else if (wr_en && sel == SEL_ARB) arb_q <= (bus_wdata & M_ARB) | F_ARB;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en && sel == SEL_SLOT && idx[SLOT_W-1:0] == SLOT_W'(s))
                slot_q[s] <= bus_wdata & M_SLOT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         arben_q <= F_ARBEN;
        else if (wr_en && sel == SEL_ARBEN) arben_q <= (bus_wdata & M_ARBEN) | F_ARBEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          maskid_q <= R_MASKID;
        else if (wr_en && sel == SEL_MASKID) maskid_q <= maskid_q | (bus_wdata & M_MASKID);
    end

    // read-back
    always_comb begin
        unique case (sel)
            SEL_CTRL:   rd_val = ctrl_q;
            SEL_TBASE:  rd_val = tbase_q;
            SEL_FSTAT:  rd_val = fstat_q;
            SEL_FADDR:  rd_val = faddr_q;
            SEL_ARB:    rd_val = arb_q;
            SEL_SLOT:   rd_val = slot_q[idx[SLOT_W-1:0]];
            SEL_ARBEN:  rd_val = arben_q;
            SEL_MASKID: rd_val = maskid_q;
            default:    rd_val = plain_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en) rdata_q <= rd_val;
        end
    end

    assign bus_rdata   = rdata_q;
    assign bus_rvalid  = rvalid_q;
    assign xlate_en    = ctrl_q[0];
    assign window_base = window_q;
    assign table_base  = tbase_q;

    a_r3_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (window_base == '0) ||
        ((window_base[23:0] == '0) && window_base[31] &&
         (((~window_base) & ((~window_base) + 32'd1)) == '0)));
    a_r7_maskid_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(maskid_q) & ~maskid_q) == '0));
    a_r5_fstat_bit23: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_FSTAT) |=> bus_rdata[23]);
    a_r10_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
endmodule

// File: tb/iommu_csr_tb.sv
`timescale 1ns/1ps
module iommu_csr_tb;
    localparam logic [7:0] TB_VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flt_load = 1'b0;
    logic [31:0] flt_status = '0, flt_addr = '0;
    logic        xlate_en;
    logic [31:0] window_base, table_base;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [31:0] model [4096];
    logic        irq_m;
    logic [31:0] win_m;

    always #2.5 clk = ~clk;

    iommu_csr #(.VERSION(TB_VER), .ADDR_W(14)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .flt_load(flt_load), .flt_status(flt_status), .flt_addr(flt_addr),
        .xlate_en(xlate_en), .window_base(window_base), .table_base(table_base),
        .irq(irq)
    );

    function automatic logic [31:0] f_apply(int w, logic [31:0] old, logic [31:0] d);
        if (w == 'h000) return (d & 32'h0000_001d) | {TB_VER, 24'h0};
        if (w == 'h001) return d & 32'h07ff_fc00;
        if (w == 'h400) return (d & 32'hff0f_ffff) | 32'h0080_0000;
        if (w == 'h402) return (d & 32'h801f_000f) | 32'h1;
        if (w >= 'h404 && w <= 'h407) return d & 32'h0001_0003;
        if (w == 'h800) return (d & 32'h001f_0000) | 32'h8;
        if (w == 'hC06) return old | (d & 32'h00ff_ffff);
        return d;
    endfunction

    function automatic logic [31:0] f_window(logic [2:0] code);
        return 32'hFFFF_FFFF << (24 + int'(code));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) model[i] = '0;
        model['h000] = {TB_VER, 24'h0};
        model['h800] = 32'h8;
        model['h400] = 32'h0080_0000;
        model['h402] = 32'h3;
        model['hC06] = 32'h2300_0000;
        irq_m = 1'b0;
        win_m = '0;
    endtask

    // one access cycle, then check at the following negedge
    task automatic step(bit s, bit w, logic [13:0] a, logic [31:0] d,
                        bit fl, logic [31:0] fs, logic [31:0] fa, string tag);
        int          wi;
        logic [31:0] exp_rd;
        wi = int'(a[13:2]);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        flt_load = fl; flt_status = fs; flt_addr = fa;
        exp_rd = model[wi];
        if (s && w) begin
            model[wi] = f_apply(wi, model[wi], d);
            if (wi == 0) win_m = f_window(d[4:2]);
        end
        if (fl) begin
            model['h400] = fs | 32'h0080_0000;
            model['h401] = fa;
            irq_m = 1'b1;
        end else if (s && (wi == 'h400 || wi == 'h401)) begin
            irq_m = 1'b0;
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; flt_load = 1'b0;
        if (s && !w) begin
            chk({tag, " R10 rvalid"}, {31'h0, bus_rvalid}, 32'h1);
            chk(tag, bus_rdata, exp_rd);
        end
        chk("R8/R9/R12 irq", {31'h0, irq}, {31'h0, irq_m});
        chk("R3 window_base", window_base, win_m);
    endtask

    task automatic rd(int wi, string tag);
        step(1, 0, 14'(wi << 2), '0, 0, '0, '0, tag);
    endtask

    task automatic wr(int wi, logic [31:0] d, string tag);
        step(1, 1, 14'(wi << 2), d, 0, '0, '0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
        chk("R1 window reset", window_base, 32'h0);
        rd('h000, "R1 ctrl reset");
        rd('h800, "R1 arben reset");
        rd('h400, "R1 fstat reset");
        rd('h402, "R1 arb reset");
        rd('hC06, "R1 maskid reset");
        rd('h001, "R1 tbase reset");
        rd('h405, "R1 slot reset");
        rd('h123, "R1 plain reset");

        // R2 / R3 all window codes
        for (int c = 0; c < 8; c++) begin
            wr('h000, 32'hFFFF_FFE0 | (32'(c) << 2) | 32'h1, "R2 ctrl write");
            rd('h000, "R2 ctrl read");
        end
        chk("R2 xlate_en", {31'h0, xlate_en}, 32'h1);
        chk("R3 code7 window", window_base, 32'h8000_0000);
        wr('h000, 32'h0, "R3 ctrl code0");
        chk("R3 code0 window", window_base, 32'hFF00_0000);

        // R4
        wr('h001, 32'hFFFF_FFFF, "R4 tbase");
        chk("R4 table_base", table_base, 32'h07ff_fc00);
        wr('h005, 32'hDEAD_BEEF, "R4 tlb flush");
        rd('h005, "R4 tlb flush read");
        wr('h006, 32'h1234_5678, "R4 page flush");
        rd('h006, "R4 page flush read");

        // R5 / R6
        wr('h400, 32'hFFFF_FFFF, "R5 fstat write");
        rd('h400, "R5 fstat read");
        wr('h400, 32'h0, "R5 fstat zero");
        rd('h400, "R5 fstat bit23");
        wr('h401, 32'hA5A5_5A5A, "R5 faddr write");
        rd('h401, "R5 faddr read");
        wr('h402, 32'h0, "R6 arb zero");
        rd('h402, "R6 arb bit0 forced");
        for (int s = 0; s < 4; s++) begin
            wr('h404 + s, 32'hFFFF_FFFF ^ 32'(s), "R6 slot write");
            rd('h404 + s, "R6 slot read");
        end
        wr('h800, 32'hFFFF_FFF7, "R6 arben write");
        rd('h800, "R6 arben read");

        // R7
        wr('hC06, 32'hFF00_0001, "R7 maskid or1");
        wr('hC06, 32'h0000_0100, "R7 maskid or2");
        wr('hC06, 32'h0, "R7 maskid zero");
        rd('hC06, "R7 maskid accumulate");

        // R9 capture, R8 clear via read and write, R12 hold
        step(0, 0, '0, '0, 1, 32'h0000_1234, 32'hCAFE_0000, "R9 capture");
        rd('h123, "R12 unrelated read");
        rd('h400, "R9 fstat captured");
        step(0, 0, '0, '0, 1, 32'h4000_0000, 32'h1111_2222, "R9 capture2");
        rd('h401, "R8 faddr read clears");
        step(0, 0, '0, '0, 1, 32'h0, 32'h3, "R9 capture3");
        wr('h400, 32'h0, "R8 fstat write clears");
        // collision: software write plus capture in one cycle
        step(1, 1, 14'h1004, 32'h9999_9999, 1, 32'h0000_0055, 32'h7777_0000, "R9 collision");
        rd('h401, "R9 collision faddr");
        step(0, 0, '0, '0, 1, 32'h0, 32'h5, "R9 capture4");
        step(1, 0, 14'h1000, '0, 1, 32'h0000_00AA, 32'h6, "R10 read with capture");
        rd('h400, "R9 fstat after read collision");

        // R11 low address bits ignored
        step(1, 1, 14'h0AB3, 32'h0BAD_F00D, 0, '0, '0, "R11 plain write");
        step(1, 0, 14'h0AB0, '0, 0, '0, '0, "R11 plain read");

        // random traffic
        for (int n = 0; n < 2500; n++) begin
            int unsigned r;
            int          wi;
            int          pick;
            logic [31:0] d;
            bit          fl;
            r  = $urandom;
            d  = $urandom;
            fl = (r[6:4] == 3'd0);
            if (r[7]) begin
                pick = int'(r[11:8]);
                case (pick)
                    0: wi = 'h000; 1: wi = 'h001; 2: wi = 'h005; 3: wi = 'h006;
                    4: wi = 'h400; 5: wi = 'h401; 6: wi = 'h402; 7: wi = 'h404;
                    8: wi = 'h405; 9: wi = 'h406; 10: wi = 'h407; 11: wi = 'h800;
                    12: wi = 'hC06; default: wi = 'h400;
                endcase
            end else begin
                wi = int'(r[23:12]);
            end
            step(r[1:0] != 2'b00, r[2], 14'({wi, r[25:24]}), d, fl, $urandom, $urandom,
                 "R11 random read");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule